// File: doc/BRIEF.md
# Boot Command Responder

This block answers the first-stage boot conversation between a host processor and a security coprocessor. Requests arrive as 64-bit mailbox messages with a one-cycle valid strobe. Every reply goes back on a registered 64-bit reply port with its own valid strobe. The responder only serves the boot endpoint (number 255) and decodes the opcode of each request:

- It acknowledges status pings.
- It fills a six-word nonce from a random-word source and returns single nonce words on request.
- It handles the command that moves the boot forward into the protected external memory region.

The continue-boot command is not trusted on the requester's word. The responder checks a hardware lock indication for the protected region:

- If the region is locked, the command is acknowledged and a stage-done output rises and stays high. From then on, boot commands are ignored.
- If the region is not locked, the command gets no reply and the responder parks for good in a halt state that answers nothing.

Top module: `boot_cmd_responder`

## Requirements
- R1: After reset, `rsp_valid`, `stage_done` and `halted` are low, and all nonce words read back as zero.
- R2: Message layout is endpoint in bits [63:56], tag in [55:48], opcode in [47:40], param in [39:32] and data in [31:0]. Every reply copies the endpoint, tag and opcode of its request. Its param is 0 for success and 1 for an error.
- R3: Opcodes 1 and 2 to endpoint 255 are pings. Each gets a success reply with data 0 in the cycle after the request.
- R4: Opcode 3 to endpoint 255 captures six random words, one on each later cycle where `rnd_valid` is high. It replies with success and data 0 in the cycle after the sixth capture. Requests that arrive while words are being collected are dropped without a reply.
- R5: Opcode 4 to endpoint 255 with param 0 to 5 replies with success, and its data is the nonce word of that index. Word i is the (i+1)-th random word captured.
- R6: Opcode 4 with a param above 5 replies with param 1 and data 0.
- R7: Any opcode other than 1 to 5 to endpoint 255 replies with param 1 and data 0.
- R8: A request to any endpoint other than 255 replies with param 1 and data 0 and changes no state. This includes a generate opcode, which leaves the stored nonce untouched.
- R9: Opcode 5 while `boot_locked` is high replies with success and data 0 in the next cycle. From that same cycle `stage_done` stays high, and later endpoint-255 requests get no reply.
- R10: Opcode 5 while `boot_locked` is low gives no reply. From the next cycle `halted` stays high and no further request is ever answered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request message present this cycle |
| req_msg | input | 64 | Request message |
| rnd_valid | input | 1 | Random word is usable this cycle |
| rnd_word | input | 32 | Random word |
| boot_locked | input | 1 | Protected region lock indication |
| rsp_valid | output | 1 | Reply message present this cycle |
| rsp_msg | output | 64 | Reply message |
| stage_done | output | 1 | Continue-boot accepted; stays high |
| halted | output | 1 | Lock check failed; stays high |

## Verification
Each result has a fixed due cycle:

- Ping, read, error and successful continue-boot replies are due one clock after the edge that takes the request.
- A generate reply is due one clock after the edge that captures the sixth usable random word. The wait therefore stretches with every cycle where `rnd_valid` is low.
- `halted` and `stage_done` change at the same edge that decides the continue-boot.

The bench model applies these latencies at every rising edge from the inputs it drives. It compares all outputs at the falling edge, so each check samples the cycle in which the result is due.

// File: rtl/boot_rsp_pkg.sv
package boot_rsp_pkg;

    typedef struct packed {
        logic [7:0]  ep;
        logic [7:0]  tag;
        logic [7:0]  op;
        logic [7:0]  prm;
        logic [31:0] data;
    } boot_msg_t;

    typedef enum logic [1:0] {
        ST_READY,
        ST_FILL,
        ST_HALT,
        ST_DONE
    } boot_state_t;

    typedef enum logic [2:0] {
        CMD_PING,
        CMD_GEN,
        CMD_READ,
        CMD_BOOT,
        CMD_BAD,
        CMD_FOREIGN
    } boot_cmd_t;

    localparam logic [7:0] OP_PING_A = 8'd1;
    localparam logic [7:0] OP_PING_B = 8'd2;
    localparam logic [7:0] OP_GEN    = 8'd3;
    localparam logic [7:0] OP_READ   = 8'd4;
    localparam logic [7:0] OP_BOOT   = 8'd5;

    localparam logic [7:0] PRM_OK    = 8'd0;
    localparam logic [7:0] PRM_ERR   = 8'd1;

endpackage

// File: rtl/boot_cmd_decode.sv
module boot_cmd_decode
    import boot_rsp_pkg::*;
#(
    parameter int unsigned NONCE_WORDS = 6,
    parameter logic [7:0]  BOOT_EP     = 8'hFF
) (
    input  logic [7:0] ep,
    input  logic [7:0] op,
    input  logic [7:0] prm,
    output boot_cmd_t  cmd,
    output logic       idx_ok
);

    always_comb begin
        if (ep != BOOT_EP) begin
            cmd = CMD_FOREIGN;
        end else begin
            unique case (op)
                OP_PING_A, OP_PING_B: cmd = CMD_PING;
                OP_GEN:               cmd = CMD_GEN;
                OP_READ:              cmd = CMD_READ;
                OP_BOOT:              cmd = CMD_BOOT;
                default:              cmd = CMD_BAD;
            endcase
        end
        idx_ok = (32'(prm) < NONCE_WORDS);
    end

endmodule

// File: rtl/boot_nonce_store.sv
module boot_nonce_store #(
    parameter int unsigned NONCE_WORDS = 6,
    parameter int unsigned WORD_W      = 32,
    localparam int unsigned IDX_W      = (NONCE_WORDS > 1) ? $clog2(NONCE_WORDS) : 1,
    localparam int unsigned FLAT_W     = NONCE_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);

    logic [FLAT_W-1:0] flat;

    for (genvar g = 0; g < NONCE_WORDS; g++) begin : g_word
        logic [WORD_W-1:0] word_d;
        logic [WORD_W-1:0] word_q;

        always_comb begin
            word_d = word_q;
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                word_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= word_d;
            end
        end

        assign flat[g*WORD_W +: WORD_W] = word_q;
    end

    always_comb begin
        rd_data = '0;
        if (32'(rd_idx) < NONCE_WORDS) begin
            rd_data = flat[32'(rd_idx)*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/boot_cmd_responder.sv
module boot_cmd_responder
    import boot_rsp_pkg::*;
#(
    parameter int unsigned NONCE_WORDS = 6,
    parameter logic [7:0]  BOOT_EP     = 8'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [63:0] req_msg,
    input  logic        rnd_valid,
    input  logic [31:0] rnd_word,
    input  logic        boot_locked,
    output logic        rsp_valid,
    output logic [63:0] rsp_msg,
    output logic        stage_done,
    output logic        halted
);

    localparam int unsigned WORD_W = 32;
    localparam int unsigned IDX_W  = (NONCE_WORDS > 1) ? $clog2(NONCE_WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NONCE_WORDS - 1);

    typedef struct packed {
        boot_state_t      st;
        logic [IDX_W-1:0] cnt;
        logic [7:0]       h_ep;
        logic [7:0]       h_tag;
        logic [7:0]       h_op;
        logic             rsp_v;
        boot_msg_t        rsp;
    } regs_t;

    regs_t r_q, r_d;

    boot_msg_t         req;
    boot_cmd_t         cmd;
    logic              idx_ok;
    logic              wr_en;
    logic [WORD_W-1:0] rd_data;
    logic              unused_req_data;

    assign req             = boot_msg_t'(req_msg);
    assign unused_req_data = ^req.data;

    boot_cmd_decode #(
        .NONCE_WORDS (NONCE_WORDS),
        .BOOT_EP     (BOOT_EP)
    ) u_decode (
        .ep     (req.ep),
        .op     (req.op),
        .prm    (req.prm),
        .cmd    (cmd),
        .idx_ok (idx_ok)
    );

    boot_nonce_store #(
        .NONCE_WORDS (NONCE_WORDS),
        .WORD_W      (WORD_W)
    ) u_nonce (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (r_q.cnt),
        .wr_data (rnd_word),
        .rd_idx  (req.prm[IDX_W-1:0]),
        .rd_data (rd_data)
    );

    function automatic boot_msg_t make_reply(input logic [7:0] ep,
                                             input logic [7:0] tag,
                                             input logic [7:0] op,
                                             input logic [7:0] prm,
                                             input logic [31:0] data);
        boot_msg_t m;
        m.ep   = ep;
        m.tag  = tag;
        m.op   = op;
        m.prm  = prm;
        m.data = data;
        return m;
    endfunction

    always_comb begin
        r_d       = r_q;
        r_d.rsp_v = 1'b0;
        r_d.rsp   = '0;
        wr_en     = 1'b0;

        unique case (r_q.st)
            ST_READY: begin
                if (req_valid) begin
                    unique case (cmd)
                        CMD_PING: begin
                            r_d.rsp_v = 1'b1;
                            r_d.rsp   = make_reply(req.ep, req.tag, req.op, PRM_OK, '0);
                        end
                        CMD_GEN: begin
                            r_d.st    = ST_FILL;
                            r_d.cnt   = '0;
                            r_d.h_ep  = req.ep;
                            r_d.h_tag = req.tag;
                            r_d.h_op  = req.op;
                        end
                        CMD_READ: begin
                            r_d.rsp_v = 1'b1;
                            if (idx_ok) begin
                                r_d.rsp = make_reply(req.ep, req.tag, req.op, PRM_OK, rd_data);
                            end else begin
                                r_d.rsp = make_reply(req.ep, req.tag, req.op, PRM_ERR, '0);
                            end
                        end
                        CMD_BOOT: begin
                            if (boot_locked) begin
                                r_d.st    = ST_DONE;
                                r_d.rsp_v = 1'b1;
                                r_d.rsp   = make_reply(req.ep, req.tag, req.op, PRM_OK, '0);
                            end else begin
                                r_d.st = ST_HALT;
                            end
                        end
                        default: begin
                            r_d.rsp_v = 1'b1;
                            r_d.rsp   = make_reply(req.ep, req.tag, req.op, PRM_ERR, '0);
                        end
                    endcase
                end
            end

            ST_FILL: begin
                if (rnd_valid) begin
                    wr_en = 1'b1;
                    if (r_q.cnt == LAST_IDX) begin
                        r_d.st    = ST_READY;
                        r_d.cnt   = '0;
                        r_d.rsp_v = 1'b1;
                        r_d.rsp   = make_reply(r_q.h_ep, r_q.h_tag, r_q.h_op, PRM_OK, '0);
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end

            ST_DONE: begin
                if (req_valid && (cmd == CMD_FOREIGN)) begin
                    r_d.rsp_v = 1'b1;
                    r_d.rsp   = make_reply(req.ep, req.tag, req.op, PRM_ERR, '0);
                end
            end

            default: begin
                // halt state: answers nothing and never leaves
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_READY;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid  = r_q.rsp_v;
    assign rsp_msg    = r_q.rsp;
    assign stage_done = (r_q.st == ST_DONE);
    assign halted     = (r_q.st == ST_HALT);

endmodule

// File: rtl/boot_cmd_responder_chk.sv
module boot_cmd_responder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        boot_locked,
    input logic        rsp_valid,
    input logic [63:0] rsp_msg,
    input logic        stage_done,
    input logic        halted
);

    // R10: halt is permanent
    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R10: nothing is answered once halted
    a_r10_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> !rsp_valid);

    // R9: stage done is permanent
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stage_done |=> stage_done);

    // R9: stage done only follows a locked region, together with a success reply
    a_r9_done_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage_done) |-> ($past(boot_locked) && rsp_valid && rsp_msg[39:32] == 8'h00));

    // R9 / R10: the two end states exclude each other
    a_r9_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(halted && stage_done));

    // R8: foreign endpoint replies carry the error code
    a_r8_foreign_err: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_msg[63:56] != 8'hFF) |-> (rsp_msg[39:32] == 8'h01 && rsp_msg[31:0] == 32'h0));

    // R2: reply param is only ever success or error
    a_r2_param_code: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_msg[39:32] <= 8'h01));

    // R3: ping replies are plain successes
    a_r3_ping_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_msg[63:56] == 8'hFF && (rsp_msg[47:40] == 8'd1 || rsp_msg[47:40] == 8'd2))
        |-> (rsp_msg[39:32] == 8'h00 && rsp_msg[31:0] == 32'h0));

endmodule

bind boot_cmd_responder boot_cmd_responder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .boot_locked (boot_locked),
    .rsp_valid   (rsp_valid),
    .rsp_msg     (rsp_msg),
    .stage_done  (stage_done),
    .halted      (halted)
);

// File: tb/boot_cmd_responder_bench.sv
module boot_cmd_responder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_msg = '0;
    logic        rnd_valid = 1'b1;
    logic [31:0] rnd_word = 32'h1234_5678;
    logic        boot_locked = 1'b0;
    logic        rsp_valid;
    logic [63:0] rsp_msg;
    logic        stage_done;
    logic        halted;

    int    checks = 0;
    int    fails = 0;
    bit    finished = 0;
    bit    rnd_toggle = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // reference model state
    int          m_mode;       // 0 ready, 1 collecting, 2 halted, 3 done
    int          m_cnt;
    logic [31:0] m_nonce [6];
    logic [23:0] m_hdr;
    logic        m_v;
    logic [63:0] m_msg;

    boot_cmd_responder u_boot_cmd_responder (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_msg     (req_msg),
        .rnd_valid   (rnd_valid),
        .rnd_word    (rnd_word),
        .boot_locked (boot_locked),
        .rsp_valid   (rsp_valid),
        .rsp_msg     (rsp_msg),
        .stage_done  (stage_done),
        .halted      (halted)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // random source, changes every cycle
    always @(negedge clk) begin
        cyc++;
        rnd_word  <= rnd_word * 32'd1103515245 + 32'd12345;
        rnd_valid <= rnd_toggle ? ((cyc % 3) != 0) : 1'b1;
    end

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_v = 0; m_msg = '0; m_hdr = '0;
            foreach (m_nonce[i]) m_nonce[i] = '0;
        end else begin
            logic [7:0] ep, tg, op, pr;
            ep = req_msg[63:56]; tg = req_msg[55:48];
            op = req_msg[47:40]; pr = req_msg[39:32];
            m_v = 0; m_msg = '0;
            if (m_mode == 0) begin
                if (req_valid) begin
                    if (ep != 8'hFF) begin
                        m_v = 1; m_msg = {ep, tg, op, 8'd1, 32'd0};
                    end else if (op == 1 || op == 2) begin
                        m_v = 1; m_msg = {ep, tg, op, 8'd0, 32'd0};
                    end else if (op == 3) begin
                        m_mode = 1; m_cnt = 0; m_hdr = {ep, tg, op};
                    end else if (op == 4) begin
                        m_v = 1;
                        if (pr < 6) m_msg = {ep, tg, op, 8'd0, m_nonce[pr]};
                        else        m_msg = {ep, tg, op, 8'd1, 32'd0};
                    end else if (op == 5) begin
                        if (boot_locked) begin
                            m_mode = 3; m_v = 1; m_msg = {ep, tg, op, 8'd0, 32'd0};
                        end else begin
                            m_mode = 2;
                        end
                    end else begin
                        m_v = 1; m_msg = {ep, tg, op, 8'd1, 32'd0};
                    end
                end
            end else if (m_mode == 1) begin
                if (rnd_valid) begin
                    m_nonce[m_cnt] = rnd_word;
                    m_cnt++;
                    if (m_cnt == 6) begin
                        m_mode = 0; m_v = 1; m_msg = {m_hdr, 8'd0, 32'd0};
                    end
                end
            end else if (m_mode == 3) begin
                if (req_valid && ep != 8'hFF) begin
                    m_v = 1; m_msg = {ep, tg, op, 8'd1, 32'd0};
                end
            end
        end
    end

    // compare on every clock, away from the rising edge
    always @(negedge clk) begin
        if (!finished) begin
            logic [66:0] act, exp;
            act = {rsp_valid, rsp_valid ? rsp_msg : 64'd0, stage_done, halted};
            exp = {m_v, m_v ? m_msg : 64'd0, (m_mode == 3), (m_mode == 2)};
            checks++;
            if (act !== exp) begin
                fails++;
                $display("FAIL %s: cycle %0d actual v=%0b msg=%h done=%0b halt=%0b expected v=%0b msg=%h done=%0b halt=%0b",
                         cur_req, cyc, act[66], act[65:2], act[1], act[0],
                         exp[66], exp[65:2], exp[1], exp[0]);
            end
        end
    end

    task automatic send(input logic [7:0] ep, input logic [7:0] tg,
                        input logic [7:0] op, input logic [7:0] pr);
        @(negedge clk);
        req_valid = 1'b1;
        req_msg   = {ep, tg, op, pr, 32'hDEAD_0000 | 32'(tg)};
        @(negedge clk);
        req_valid = 1'b0;
        req_msg   = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung run expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset state, nonce reads zero before generation
        cur_req = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(2);
        send(8'hFF, 8'h10, 8'd4, 8'd0);
        send(8'hFF, 8'h11, 8'd4, 8'd5);
        idle(2);

        // R3 and R2: pings with different tags, header copied
        cur_req = "R3";
        send(8'hFF, 8'hA5, 8'd1, 8'd0);
        send(8'hFF, 8'h5A, 8'd2, 8'd7);
        cur_req = "R2";
        send(8'hFF, 8'h00, 8'd1, 8'hFF);
        idle(2);

        // R4: generate with steady random source, request during fill dropped
        cur_req = "R4";
        send(8'hFF, 8'h30, 8'd3, 8'd0);
        send(8'hFF, 8'h31, 8'd1, 8'd0);
        idle(10);

        // R5: read every word
        cur_req = "R5";
        for (int i = 0; i < 6; i++) send(8'hFF, 8'(8'h40 + i), 8'd4, 8'(i));
        idle(2);

        // R4: generate again with gaps in the random source
        cur_req = "R4";
        rnd_toggle = 1;
        send(8'hFF, 8'h32, 8'd3, 8'd0);
        idle(15);
        rnd_toggle = 0;
        cur_req = "R5";
        for (int i = 5; i >= 0; i--) send(8'hFF, 8'(8'h50 + i), 8'd4, 8'(i));

        // R6: index out of range
        cur_req = "R6";
        send(8'hFF, 8'h60, 8'd4, 8'd6);
        send(8'hFF, 8'h61, 8'd4, 8'd255);

        // R7: unknown opcodes
        cur_req = "R7";
        send(8'hFF, 8'h70, 8'd0, 8'd0);
        send(8'hFF, 8'h71, 8'd6, 8'd0);
        send(8'hFF, 8'h72, 8'h80, 8'd0);

        // R8: foreign endpoints, state untouched
        cur_req = "R8";
        send(8'h00, 8'h80, 8'd1, 8'd0);
        send(8'h07, 8'h81, 8'd3, 8'd0);
        idle(8);
        send(8'hFF, 8'h82, 8'd4, 8'd2);
        send(8'hFE, 8'h83, 8'd5, 8'd0);
        idle(2);

        // R9: continue-boot with lock, then ignore boot commands
        cur_req = "R9";
        boot_locked = 1'b1;
        send(8'hFF, 8'h90, 8'd5, 8'd0);
        idle(2);
        send(8'hFF, 8'h91, 8'd1, 8'd0);
        send(8'hFF, 8'h92, 8'd5, 8'd0);
        send(8'hFF, 8'h93, 8'd3, 8'd0);
        idle(8);
        send(8'h0C, 8'h94, 8'd1, 8'd0);
        idle(3);

        // R10: continue-boot without lock parks the responder
        cur_req = "R10";
        rst_n = 1'b0;
        boot_locked = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        send(8'hFF, 8'hA0, 8'd1, 8'd0);
        send(8'hFF, 8'hA1, 8'd5, 8'd0);
        idle(2);
        boot_locked = 1'b1;
        send(8'hFF, 8'hA2, 8'd1, 8'd0);
        send(8'hFF, 8'hA3, 8'd5, 8'd0);
        send(8'h01, 8'hA4, 8'd1, 8'd0);
        idle(5);

        finish_run();
    end

endmodule